// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block is the multi-cycle control unit of a small accumulator machine. It runs every instruction as a series of register transfers through a program counter (PC), a memory address register (MAR), a memory buffer register (MBR) and an instruction register (IR). The steps are an instruction fetch, an optional pointer-chasing subcycle for indirect operands, an execute step, and an interrupt check that closes the cycle before the next fetch.

All traffic goes through one synchronous single-port memory. The address always comes from the MAR and the write data always comes from the MBR. A read returns its word one clock after the read strobe. The sequencer spends one wait cycle on every read before it captures the word into the MBR.

An instruction word is 16 bits. Bits 15:12 hold the opcode, bit 11 is the indirect flag and bits 10:0 are the address field. The machine has an 11-bit address space.

Top module: `icyc_seq`

## Requirements
- R1: `rst` is synchronous and active high. It clears the PC, the accumulator and the interrupt-enable flag. While `rst` is high, and in the first cycle after it falls, neither strobe is asserted. The first read strobe, to address 0, appears in the cycle that follows the first clock edge with `rst` low.
- R2: Each instruction word is read from the address held in the PC. The PC advances by exactly one during that fetch read, so instructions execute at consecutive addresses unless a jump intervenes. Word layout: opcode in bits 15:12, indirect flag in bit 11, address field in bits 10:0.
- R3: Opcode 0x1 loads the accumulator from memory at the effective address. Opcode 0x2 writes the accumulator to memory at the effective address.
- R4: Opcode 0x3 adds the word at the effective address to the accumulator, modulo 2^16.
- R5: For opcodes 0x1 to 0x4 with bit 11 set, the word at the address field is read first, and its bits 10:0 become the effective address. With bit 11 clear, the address field itself is the effective address.
- R6: Opcode 0x4 makes the next fetch come from the effective address.
- R7: Opcodes 0x0 and 0x6 to 0xF do nothing. They make no memory access beyond their own fetch, even with bit 11 set. They leave the accumulator unchanged, and the next fetch comes from the following address.
- R8: Opcode 0x5 sets the interrupt-enable flag. `irq` is examined only in the check step after execute. An interrupt is taken only when `irq` is high and the flag is set.
- R9: Taking an interrupt writes the address of the next instruction, zero-extended, to address 0. The next fetch then comes from address 1, and the enable flag is cleared, so a request that stays high is not taken again until opcode 0x5 runs.
- R10: The read and write strobes are never high together. Read data is taken from the memory in the cycle after the read strobe.
- R11: The distance between consecutive fetch reads, in cycles, is fixed by the instruction: 6 for no-op and opcode 0x5, 7 for jump, 8 for store, and 10 for load and add. Indirect operands add 3, and a taken interrupt adds 1. A direct operand read comes 5 cycles after its fetch read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 11 | Memory address, driven from the MAR |
| mem_rd | output | 1 | Read strobe; data returns one clock later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data, driven from the MBR |
| mem_rdata | input | 16 | Read data from memory |
| irq | input | 1 | Interrupt request level |

## Verification
The hardest situation to reach from the ports is interrupt entry together with its re-arming. It needs the enable flag set by an executed opcode while a request is already pending. It also needs proof that the request, still held high, is ignored after the handler starts and until the enable opcode runs again. The bench holds `irq` high from reset through a program that jumps, loads and then enables. It checks that nothing is taken before the enable opcode and that the return address lands in slot 0. It then checks that the handler's store completes uninterrupted before the program loops back into the enable opcode. Random straight-line programs mixing direct and indirect loads, adds, stores and no-ops are compared against an instruction-level model kept in the bench, with fixed cycle-exact read timing checks on a directed program.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 11;
    localparam int OPC_W  = WORD_W - ADDR_W - 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [OPC_W-1:0]  opc_t;

    localparam opc_t OPC_LOAD  = opc_t'(1);
    localparam opc_t OPC_STORE = opc_t'(2);
    localparam opc_t OPC_ADD   = opc_t'(3);
    localparam opc_t OPC_JUMP  = opc_t'(4);
    localparam opc_t OPC_INTEN = opc_t'(5);

    localparam addr_t SAVE_SLOT = addr_t'(0);
    localparam addr_t ENTRY_VEC = addr_t'(1);

    // Full view of a memory word as an instruction
    typedef struct packed {
        opc_t  opc;
        logic  ind;
        addr_t field;
    } instr_t;

    // Decode part kept in the IR; the address field is used from the MBR
    typedef struct packed {
        opc_t opc;
        logic ind;
    } dec_t;

    typedef enum logic [3:0] {
        S_FETCH, S_FRD, S_FWAIT, S_IR, S_DEC,
        S_IADR, S_IRD, S_IWAIT,
        S_XADR, S_XRD, S_XWAIT, S_XALU, S_XWR,
        S_ICHK, S_ISAVE
    } state_e;

    typedef enum logic [1:0] {MAR_PC, MAR_FIELD, MAR_ZERO} mar_sel_e;
    typedef enum logic [1:0] {MBR_RDATA, MBR_ACC, MBR_PC} mbr_sel_e;
    typedef enum logic {ACC_PASS, ACC_ADD} acc_op_e;

    typedef struct packed {
        logic     mar_ld;
        mar_sel_e mar_sel;
        logic     mbr_ld;
        mbr_sel_e mbr_sel;
        logic     ir_ld;
        logic     pc_inc;
        logic     pc_jump;
        logic     pc_vec;
        logic     acc_ld;
        acc_op_e  acc_op;
        logic     ie_set;
        logic     ie_clr;
        logic     rd;
        logic     wr;
    } ctrl_t;

    function automatic logic uses_operand(opc_t o);
        return (o == OPC_LOAD) || (o == OPC_STORE) || (o == OPC_ADD) || (o == OPC_JUMP);
    endfunction

endpackage

// File: rtl/icyc_alu.sv
module icyc_alu
    import icyc_pkg::*;
(
    input  acc_op_e op,
    input  word_t   acc,
    input  word_t   opnd,
    output word_t   y
);
    always_comb begin
        case (op)
            ACC_ADD: y = acc + opnd;
            default: y = opnd;
        endcase
    end
endmodule

// File: rtl/icyc_regs.sv
module icyc_regs
    import icyc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctl,
    input  word_t rdata,
    input  word_t alu_y,
    output addr_t pc,
    output addr_t mar,
    output word_t mbr,
    output word_t acc,
    output dec_t  ir,
    output logic  ie
);
    instr_t mbr_i;
    addr_t  mar_d;
    word_t  mbr_d;

    assign mbr_i = instr_t'(mbr);

    always_comb begin
        case (ctl.mar_sel)
            MAR_PC:    mar_d = pc;
            MAR_FIELD: mar_d = mbr_i.field;
            default:   mar_d = SAVE_SLOT;
        endcase
    end

    always_comb begin
        case (ctl.mbr_sel)
            MBR_ACC: mbr_d = acc;
            MBR_PC:  mbr_d = word_t'(pc);
            default: mbr_d = rdata;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            mar <= '0;
            mbr <= '0;
            acc <= '0;
            ir  <= '0;
            ie  <= 1'b0;
        end else begin
            if (ctl.mar_ld) mar <= mar_d;
            if (ctl.mbr_ld) mbr <= mbr_d;
            if (ctl.ir_ld)  ir  <= '{opc: mbr_i.opc, ind: mbr_i.ind};
            if (ctl.acc_ld) acc <= alu_y;

            if (ctl.pc_vec)       pc <= ENTRY_VEC;
            else if (ctl.pc_jump) pc <= mbr_i.field;
            else if (ctl.pc_inc)  pc <= pc + 1'b1;

            if (ctl.ie_clr)      ie <= 1'b0;
            else if (ctl.ie_set) ie <= 1'b1;
        end
    end
endmodule

// File: rtl/icyc_ctrl.sv
module icyc_ctrl
    import icyc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  dec_t   ir,
    input  logic   irq,
    input  logic   ie,
    output state_e state,
    output ctrl_t  ctl
);
    state_e nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= S_FETCH;
        else     state <= nxt;
    end

    always_comb begin
        ctl = '0;
        nxt = state;
        case (state)
            // fetch: PC -> MAR, read with PC+1, wait, MBR -> IR, decode
            S_FETCH: begin
                ctl.mar_ld  = 1'b1;
                ctl.mar_sel = MAR_PC;
                nxt         = S_FRD;
            end
            S_FRD: begin
                ctl.rd     = 1'b1;
                ctl.pc_inc = 1'b1;
                nxt        = S_FWAIT;
            end
            S_FWAIT: begin
                ctl.mbr_ld  = 1'b1;
                ctl.mbr_sel = MBR_RDATA;
                nxt         = S_IR;
            end
            S_IR: begin
                ctl.ir_ld = 1'b1;
                nxt       = S_DEC;
            end
            S_DEC: begin
                if (!uses_operand(ir.opc)) begin
                    ctl.ie_set = (ir.opc == OPC_INTEN);
                    nxt        = S_ICHK;
                end else if (ir.ind) begin
                    nxt = S_IADR;
                end else begin
                    nxt = S_XADR;
                end
            end
            // indirect: field -> MAR, read, pointer word -> MBR
            S_IADR: begin
                ctl.mar_ld  = 1'b1;
                ctl.mar_sel = MAR_FIELD;
                nxt         = S_IRD;
            end
            S_IRD: begin
                ctl.rd = 1'b1;
                nxt    = S_IWAIT;
            end
            S_IWAIT: begin
                ctl.mbr_ld  = 1'b1;
                ctl.mbr_sel = MBR_RDATA;
                nxt         = S_XADR;
            end
            // execute
            S_XADR: begin
                ctl.mar_ld  = 1'b1;
                ctl.mar_sel = MAR_FIELD;
                if (ir.opc == OPC_JUMP) begin
                    ctl.pc_jump = 1'b1;
                    nxt         = S_ICHK;
                end else if (ir.opc == OPC_STORE) begin
                    ctl.mbr_ld  = 1'b1;
                    ctl.mbr_sel = MBR_ACC;
                    nxt         = S_XWR;
                end else begin
                    nxt = S_XRD;
                end
            end
            S_XRD: begin
                ctl.rd = 1'b1;
                nxt    = S_XWAIT;
            end
            S_XWAIT: begin
                ctl.mbr_ld  = 1'b1;
                ctl.mbr_sel = MBR_RDATA;
                nxt         = S_XALU;
            end
            S_XALU: begin
                ctl.acc_ld = 1'b1;
                ctl.acc_op = (ir.opc == OPC_ADD) ? ACC_ADD : ACC_PASS;
                nxt        = S_ICHK;
            end
            S_XWR: begin
                ctl.wr = 1'b1;
                nxt    = S_ICHK;
            end
            // interrupt check and entry
            S_ICHK: begin
                if (irq && ie) begin
                    ctl.mar_ld  = 1'b1;
                    ctl.mar_sel = MAR_ZERO;
                    ctl.mbr_ld  = 1'b1;
                    ctl.mbr_sel = MBR_PC;
                    nxt         = S_ISAVE;
                end else begin
                    nxt = S_FETCH;
                end
            end
            S_ISAVE: begin
                ctl.wr     = 1'b1;
                ctl.pc_vec = 1'b1;
                ctl.ie_clr = 1'b1;
                nxt        = S_FETCH;
            end
            default: nxt = S_FETCH;
        endcase
    end
endmodule

// File: rtl/icyc_seq.sv
module icyc_seq
    import icyc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              irq
);
    state_e st;
    ctrl_t  ctl;
    addr_t  pc_q;
    addr_t  mar_q;
    word_t  mbr_q;
    word_t  acc_q;
    word_t  alu_y;
    dec_t   ir_q;
    logic   ie_q;

    icyc_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .ir    (ir_q),
        .irq   (irq),
        .ie    (ie_q),
        .state (st),
        .ctl   (ctl)
    );

    icyc_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .rdata (mem_rdata),
        .alu_y (alu_y),
        .pc    (pc_q),
        .mar   (mar_q),
        .mbr   (mbr_q),
        .acc   (acc_q),
        .ir    (ir_q),
        .ie    (ie_q)
    );

    icyc_alu u_alu (
        .op   (ctl.acc_op),
        .acc  (acc_q),
        .opnd (mbr_q),
        .y    (alu_y)
    );

    assign mem_addr  = mar_q;
    assign mem_wdata = mbr_q;
    assign mem_rd    = ctl.rd;
    assign mem_wr    = ctl.wr;
endmodule

// File: rtl/icyc_seq_chk.sv
module icyc_seq_chk
    import icyc_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input state_e state,
    input addr_t  pc,
    input logic   ie,
    input logic   irq,
    input logic   mem_rd,
    input logic   mem_wr,
    input addr_t  mem_addr
);
    // R1
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!mem_rd && !mem_wr && pc == '0 && !ie));

    // R2
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        (state == S_FRD) |=> (pc == addr_t'($past(pc) + 1'b1)));

    // R8
    a_r8_no_entry: assert property (@(posedge clk) disable iff (rst)
        (state == S_ICHK && !(irq && ie)) |=> (state == S_FETCH));

    // R8
    a_r8_entry: assert property (@(posedge clk) disable iff (rst)
        (state == S_ICHK && irq && ie) |=> (state == S_ISAVE));

    // R9
    a_r9_save_slot: assert property (@(posedge clk) disable iff (rst)
        (state == S_ISAVE) |-> (mem_wr && mem_addr == SAVE_SLOT));

    // R9
    a_r9_vector: assert property (@(posedge clk) disable iff (rst)
        (state == S_ISAVE) |=> (pc == ENTRY_VEC && !ie && state == S_FETCH));

    // R10
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R10
    a_r10_wait_after_read: assert property (@(posedge clk) disable iff (rst)
        (state == S_FWAIT || state == S_IWAIT || state == S_XWAIT) |-> $past(mem_rd));
endmodule

bind icyc_seq icyc_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .state    (st),
    .pc       (pc_q),
    .ie       (ie_q),
    .irq      (irq),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr)
);

// File: tb/icyc_seq_tb.sv
`timescale 1ns/1ps
module icyc_seq_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [10:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        irq;

    logic        ld_en;
    logic [10:0] ld_addr;
    logic [15:0] ld_data;

    logic [15:0] mem  [0:2047];
    logic [15:0] refm [0:2047];

    int chk_cnt  = 0;
    int fail_cnt = 0;

    int cyc, rn, wn, both;
    int raddr [0:255];
    int rcyc  [0:255];
    int waddr [0:63];
    int wdat  [0:63];

    int ewa [0:63];
    int ewd [0:63];
    int en;

    always #4 clk = ~clk;

    icyc_seq u_dut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .irq       (irq)
    );

    // memory model: loader port while in reset, one-cycle read latency
    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    // bus monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            cyc = 0; rn = 0; wn = 0; both = 0;
        end else begin
            cyc++;
            if (mem_rd && rn < 256) begin raddr[rn] = int'(mem_addr); rcyc[rn] = cyc; rn++; end
            if (mem_wr && wn < 64)  begin waddr[wn] = int'(mem_addr); wdat[wn] = int'(mem_wdata); wn++; end
            if (mem_rd && mem_wr) both++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk_cnt++;
        fail_cnt++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", chk_cnt - fail_cnt, chk_cnt);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        chk_cnt++;
        if (!ok) begin
            fail_cnt++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input int op, input int ind, input int a);
        return {op[3:0], ind[0], a[10:0]};
    endfunction

    task automatic begin_load();
        @(negedge clk);
        rst   = 1'b1;
        ld_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic put(input int a, input logic [15:0] d);
        ld_en   = 1'b1;
        ld_addr = a[10:0];
        ld_data = d;
        refm[a] = d;
        @(negedge clk);
    endtask

    task automatic start_run();
        ld_en = 1'b0;
        rst   = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    // instruction-level model of the requirements
    task automatic ref_run(input int n);
        logic [10:0] pc = '0;
        logic [15:0] acc = '0;
        logic [15:0] w;
        logic [3:0]  op;
        logic [10:0] ea;
        en = 0;
        for (int i = 0; i < n; i++) begin
            w  = refm[pc];
            pc = pc + 1'b1;
            op = w[15:12];
            ea = w[10:0];
            if ((op >= 4'h1 && op <= 4'h4) && w[11]) ea = refm[ea][10:0];
            case (op)
                4'h1: acc = refm[ea];
                4'h2: begin refm[ea] = acc; ewa[en] = int'(ea); ewd[en] = int'(acc); en++; end
                4'h3: acc = acc + refm[ea];
                4'h4: pc = ea;
                default: ;
            endcase
        end
    endtask

    initial begin
        int exp_ra [0:13];
        int exp_rc [0:13];
        string tag;
        void'($urandom(32'd4242));
        rst   = 1'b1;
        irq   = 1'b0;
        ld_en = 1'b0;
        ld_addr = '0;
        ld_data = '0;

        // ---------- directed program: load/add/store/indirect/jump/no-op ----------
        begin_load();
        chk(!mem_rd && !mem_wr, "R1 strobes in reset", {mem_rd, mem_wr}, 0);
        put(0,  enc(1, 0, 100));
        put(1,  enc(3, 0, 101));
        put(2,  enc(2, 0, 102));
        put(3,  enc(1, 1, 103));
        put(4,  enc(2, 1, 104));
        put(5,  enc(4, 0, 10));
        put(6,  enc(2, 0, 105));
        put(10, enc(15, 1, 100));
        put(11, enc(2, 0, 106));
        put(12, enc(4, 0, 12));
        put(100, 16'hFFF0);
        put(101, 16'h0020);
        put(102, 16'h0000);
        put(103, 16'd200);
        put(104, 16'd300);
        put(105, 16'h0000);
        put(106, 16'h0000);
        put(200, 16'h1234);
        put(300, 16'h0000);
        start_run();
        #1;
        chk(!mem_rd && !mem_wr, "R1 strobes right after reset", {mem_rd, mem_wr}, 0);
        @(negedge clk);
        chk(mem_rd && mem_addr == 11'd0, "R1 first fetch at 0", {mem_rd, mem_addr}, {1'b1, 11'd0});
        run(99);

        exp_ra = '{0, 100, 1, 101, 2, 3, 103, 200, 4, 104, 5, 10, 11, 12};
        exp_rc = '{0, 5, 10, 15, 20, 28, 33, 36, 41, 46, 52, 59, 65, 73};
        for (int i = 0; i < 14; i++) begin
            tag = (i == 6 || i == 7 || i == 9) ? "R5 read order" :
                  (i == 11) ? "R6 jump target" :
                  (i == 12) ? "R7 no-op skips operand" : "R2 read order";
            chk(raddr[i] == exp_ra[i], tag, raddr[i], exp_ra[i]);
            chk(rcyc[i] - rcyc[0] == exp_rc[i], "R11 read timing", rcyc[i] - rcyc[0], exp_rc[i]);
        end
        chk(wn == 3, "R6 write count (skipped store)", wn, 3);
        chk(waddr[0] == 102 && wdat[0] == 16'h0010, "R4 wrapped sum stored", wdat[0], 16'h0010);
        chk(waddr[1] == 300 && wdat[1] == 16'h1234, "R5 indirect store", waddr[1], 300);
        chk(waddr[2] == 106 && wdat[2] == 16'h1234, "R7 acc kept over no-op", wdat[2], 16'h1234);
        chk(mem[105] == 16'h0000, "R6 jumped-over store", int'(mem[105]), 0);
        chk(both == 0, "R10 rd and wr together", both, 0);

        // ---------- interrupt entry, gating and re-arm ----------
        begin_load();
        put(0, enc(4, 0, 2));
        put(1, enc(2, 0, 50));
        put(2, enc(1, 0, 40));
        put(3, enc(5, 0, 0));
        put(4, enc(4, 0, 4));
        put(40, 16'hBEEF);
        put(50, 16'h0000);
        irq = 1'b1;
        start_run();
        run(100);
        chk(raddr[1] == 2 && raddr[3] == 3, "R8 not taken while disabled", raddr[3], 3);
        chk(waddr[0] == 0 && wdat[0] == 4, "R9 return address saved", wdat[0], 4);
        chk(raddr[4] == 1, "R9 entry fetch address", raddr[4], 1);
        chk(rcyc[4] - rcyc[3] == 7, "R11 interrupt adds a cycle", rcyc[4] - rcyc[3], 7);
        chk(waddr[1] == 50 && wdat[1] == 16'hBEEF, "R9 handler runs, enable cleared", wdat[1], 16'hBEEF);
        chk(raddr[5] == 2, "R9 handler falls through", raddr[5], 2);
        chk(waddr[2] == 0 && wdat[2] == 4, "R8 re-enabled entry", wdat[2], 4);
        chk(both == 0, "R10 rd and wr together", both, 0);
        irq = 1'b0;

        // ---------- random straight-line programs vs. model ----------
        for (int p = 0; p < 30; p++) begin
            int sel, ind, a, op, mism;
            begin_load();
            for (int i = 0; i < 24; i++) begin
                sel = int'($urandom % 5);
                ind = int'($urandom % 2);
                a   = ind ? 128 + int'($urandom % 16) : 64 + int'($urandom % 64);
                case (sel)
                    0, 4: op = 1;
                    1:    op = 3;
                    2:    op = 2;
                    default: begin
                        op = int'($urandom % 11);
                        if (op != 0) op = op + 5;
                    end
                endcase
                put(i, enc(op, ind, a));
            end
            put(24, enc(4, 0, 24));
            for (int i = 64; i < 128; i++) put(i, 16'($urandom));
            for (int i = 128; i < 144; i++) put(i, {5'($urandom), 11'(64 + ($urandom % 64))});
            ref_run(40);
            start_run();
            run(24 * 13 + 40);
            chk(wn == en, "R3 store count", wn, en);
            for (int i = 0; i < en && i < wn; i++) begin
                chk(waddr[i] == ewa[i], "R5 store address", waddr[i], ewa[i]);
                chk(wdat[i] == ewd[i], "R4 stored value", wdat[i], ewd[i]);
            end
            mism = 0;
            for (int i = 64; i < 128; i++) if (mem[i] !== refm[i]) mism++;
            chk(mism == 0, "R3 memory image", mism, 0);
            chk(both == 0, "R10 rd and wr together", both, 0);
        end

        $display("%0d/%0d checks passed", chk_cnt - fail_cnt, chk_cnt);
        $finish;
    end
endmodule